// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Bridge

This block sits between the internal control logic and an external controller chip whose registers are eight bits wide and are selected by eight-bit addresses. The internal side issues a simple request: a one-cycle `go` with a direction bit, an address and, for writes, a data byte. The bridge turns that request into one transaction on a shared address/data bus. An address-latch strobe opens the transaction. A low-active read or write strobe follows, and the data byte is valid when that strobe rises. The bidirectional bus pins appear as separate output, input and output-enable signals.

The bridge runs from the fast input clock and divides it by `DIV` (four by default) to make the slow clock that the rest of the logic uses. Requests are sampled only on the fast edge where the slow clock rises. The whole bus conversation fits inside the next slow cycle, and `done` is then high for exactly one slow cycle. The result is that a transaction takes two slow cycles from `go` to `done`, and a new request may be sampled on the same slow edge that sees `done`.

Top module: `mux_bus_bridge`

## Requirements
- R1: `slow_clk_o` has period `DIV` fast cycles with `DIV/2` high and `DIV/2` low. It is high during the first fast cycle after reset, and each of its rising edges coincides with a request sampling edge.
- R2: `go_i` (with `rw_i`, `addr_i`, `wdata_i`) is sampled only on the fast edge where `slow_clk_o` rises and the bridge is idle or in the last fast cycle of `done`. A `go_i` pulse at any other edge starts nothing.
- R3: A transaction begins with `ale_o` high for exactly one fast cycle. During that cycle and the following one, `ad_o` carries the latched address and `ad_oe_o` is 1.
- R4: For a read (`rw_i`=1), `rd_n_o` is low for `DIV-2` fast cycles starting two cycles after `ale_o` rises. `ad_oe_o` is 0 during the strobe and `wr_n_o` stays 1.
- R5: For a write (`rw_i`=0), `wr_n_o` is low for `DIV-2` fast cycles starting two cycles after `ale_o` rises. `ad_o` carries the write data with `ad_oe_o`=1 for the strobe cycles and one more cycle after the strobe rises. `rd_n_o` stays 1.
- R6: At the fast edge where `rd_n_o` rises, `ad_i` is captured into `rdata_o`. `rdata_o` changes at no other time, so writes leave it unchanged.
- R7: `done_o` is high for exactly `DIV` fast cycles (one slow cycle), starting the cycle right after the strobe rises.
- R8: While no transaction is in progress, `ale_o`=0, `rd_n_o`=1, `wr_n_o`=1, `ad_oe_o`=0 and `done_o`=0.
- R9: A request sampled in the last fast cycle of `done_o` raises `ale_o` on the very next fast cycle, with no idle gap.
- R10: While `rst_n_i` is low, the bridge is idle (as in R8), `rdata_o` is 0 and `slow_clk_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast_i | input | 1 | Fast input clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Request pulse from the slow domain |
| rw_i | input | 1 | Direction: 1 read, 0 write |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Last read data, held |
| done_o | output | 1 | Completion, one slow cycle wide |
| slow_clk_o | output | 1 | Divided clock |
| ale_o | output | 1 | Address latch strobe |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| ad_o | output | DATA_W | Shared bus, driven value |
| ad_i | input | DATA_W | Shared bus, received value |
| ad_oe_o | output | 1 | Shared bus output enable |

## Verification
Several behaviours are checked by assertions on every cycle:
- the read and write strobes are never low together;
- `ale_o` lasts one cycle and is followed by a quiet, still-driven hold cycle;
- the bus is released while `rd_n_o` is low;
- `ale_o` only rises after a sampling edge;
- `done_o` only rises right after a strobe;
- `rdata_o` only moves as `rd_n_o` rises.

Other behaviours can only be shown by the bench scenarios, which compare every output against a behavioural timing model on every fast cycle. These are the exact lengths of the strobe and `done` windows, the write-data hold cycle, read-after-write values returned through a model of the chip, requests at the wrong phase being ignored, and back-to-back requests.

// File: rtl/mib_pkg.sv
package mib_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE = 3'd0,
        SEQ_ALE  = 3'd1,
        SEQ_HOLD = 3'd2,
        SEQ_STB  = 3'd3,
        SEQ_DONE = 3'd4
    } seq_state_e;

endpackage

// File: rtl/mib_clkdiv.sv
module mib_clkdiv #(
    parameter int DIV = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    output logic [$clog2(DIV)-1:0]     phase_o,
    output logic                       wrap_o,
    output logic                       slow_clk_o
);
    localparam int PW = $clog2(DIV);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);
    localparam logic [PW-1:0] HALF = PW'(DIV / 2);

    typedef struct packed {
        logic [PW-1:0] phase;
        logic          slow;
    } div_regs_t;

    div_regs_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (div_q.phase == LAST) div_d.phase = '0;
        else                     div_d.phase = div_q.phase + 1'b1;
        div_d.slow = (div_d.phase < HALF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q.phase <= '0;
            div_q.slow  <= 1'b1;
        end else begin
            div_q <= div_d;
        end
    end

    assign phase_o    = div_q.phase;
    assign wrap_o     = (div_q.phase == LAST);
    assign slow_clk_o = div_q.slow;

    // R1: the slow clock rises right after each sampling edge
    a_r1_slow_rises_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> slow_clk_o);
    // R1: the slow clock is low in the last phase
    a_r1_slow_low_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |-> !slow_clk_o);

endmodule

// File: rtl/mib_seq.sv
module mib_seq
    import mib_pkg::*;
#(
    parameter int DIV    = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wrap_i,
    input  logic [$clog2(DIV)-1:0] phase_i,
    input  logic                   go_i,
    input  logic                   rw_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [DATA_W-1:0]      wdata_i,
    output logic                   ale_o,
    output logic                   rd_n_o,
    output logic                   wr_n_o,
    output logic [DATA_W-1:0]      ad_o,
    output logic                   ad_oe_o,
    output logic                   done_o,
    output logic                   capture_o
);
    localparam int BW = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;

    typedef struct packed {
        seq_state_e        state;
        logic              rw;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;
    logic      accept;
    logic [BW-1:0] addr_wide;

    always_comb begin
        seq_d  = seq_q;
        accept = 1'b0;
        unique case (seq_q.state)
            SEQ_IDLE: accept = wrap_i && go_i;
            SEQ_ALE:  seq_d.state = SEQ_HOLD;
            SEQ_HOLD: seq_d.state = SEQ_STB;
            SEQ_STB:  if (wrap_i) seq_d.state = SEQ_DONE;
            SEQ_DONE: begin
                if (wrap_i) begin
                    accept      = go_i;
                    seq_d.state = SEQ_IDLE;
                end
            end
            default:  seq_d.state = SEQ_IDLE;
        endcase
        if (accept) begin
            seq_d.state = SEQ_ALE;
            seq_d.rw    = rw_i;
            seq_d.addr  = addr_i;
            seq_d.wdata = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= SEQ_IDLE;
            seq_q.rw    <= 1'b1;
            seq_q.addr  <= '0;
            seq_q.wdata <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign addr_wide = BW'(seq_q.addr);

    always_comb begin
        ale_o     = (seq_q.state == SEQ_ALE);
        rd_n_o    = !((seq_q.state == SEQ_STB) && seq_q.rw);
        wr_n_o    = !((seq_q.state == SEQ_STB) && !seq_q.rw);
        done_o    = (seq_q.state == SEQ_DONE);
        capture_o = (seq_q.state == SEQ_STB) && wrap_i && seq_q.rw;
        ad_oe_o   = 1'b0;
        ad_o      = seq_q.wdata;
        unique case (seq_q.state)
            SEQ_ALE, SEQ_HOLD: begin
                ad_oe_o = 1'b1;
                ad_o    = addr_wide[DATA_W-1:0];
            end
            SEQ_STB:  ad_oe_o = !seq_q.rw;
            SEQ_DONE: ad_oe_o = !seq_q.rw && (phase_i == '0);
            default:  ad_oe_o = 1'b0;
        endcase
    end

    // R4: the two strobes are never active together
    a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n_o && !wr_n_o));
    // R3: ALE lasts one cycle, then the address is held with strobes still high
    a_r3_ale_then_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |=> !ale_o && ad_oe_o && rd_n_o && wr_n_o);
    // R4: the bridge releases the bus while the chip drives it
    a_r4_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> !ad_oe_o);
    // R2: a transaction only starts after a sampling edge
    a_r2_start_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale_o) |-> $past(wrap_i));
    // R7: completion directly follows a strobe
    a_r7_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(!rd_n_o || !wr_n_o));

endmodule

// File: rtl/mib_rdcap.sv
module mib_rdcap #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [DATA_W-1:0] ad_i,
    output logic [DATA_W-1:0] rdata_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
    } cap_regs_t;

    cap_regs_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (cap_i) cap_d.data = ad_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q.data <= '0;
        else        cap_q      <= cap_d;
    end

    assign rdata_o = cap_q.data;

endmodule

// File: rtl/mux_bus_bridge.sv
module mux_bus_bridge #(
    parameter int DIV    = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk_fast_i,
    input  logic              rst_n_i,
    input  logic              go_i,
    input  logic              rw_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o,
    output logic              slow_clk_o,
    output logic              ale_o,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic [DATA_W-1:0] ad_o,
    input  logic [DATA_W-1:0] ad_i,
    output logic              ad_oe_o
);
    localparam int PW = $clog2(DIV);

    logic [PW-1:0] phase;
    logic          wrap;
    logic          capture;

    mib_clkdiv #(.DIV(DIV)) u_div (
        .clk        (clk_fast_i),
        .rst_n      (rst_n_i),
        .phase_o    (phase),
        .wrap_o     (wrap),
        .slow_clk_o (slow_clk_o)
    );

    mib_seq #(.DIV(DIV), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk_fast_i),
        .rst_n     (rst_n_i),
        .wrap_i    (wrap),
        .phase_i   (phase),
        .go_i      (go_i),
        .rw_i      (rw_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .ale_o     (ale_o),
        .rd_n_o    (rd_n_o),
        .wr_n_o    (wr_n_o),
        .ad_o      (ad_o),
        .ad_oe_o   (ad_oe_o),
        .done_o    (done_o),
        .capture_o (capture)
    );

    mib_rdcap #(.DATA_W(DATA_W)) u_cap (
        .clk     (clk_fast_i),
        .rst_n   (rst_n_i),
        .cap_i   (capture),
        .ad_i    (ad_i),
        .rdata_o (rdata_o)
    );

    // R6: read data only moves as the read strobe is released
    a_r6_rdata_moves_on_read_end: assert property (@(posedge clk_fast_i) disable iff (!rst_n_i)
        !$rose(rd_n_o) |-> $stable(rdata_o));

endmodule

// File: tb/tb_mux_bus_bridge.sv
module tb_mux_bus_bridge;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go = 1'b0, rw = 1'b1;
    logic [7:0] addr = '0, wdata = '0;
    logic [7:0] rdata, ad_o, ad_i;
    logic       done, slow_clk, ale, rd_n, wr_n, ad_oe;

    int checks = 0, fails = 0, cycles = 0, ale_cnt = 0;
    logic prev_ale = 1'b0;
    string scn = "R8";

    always #10 clk = ~clk;

    mux_bus_bridge #(.DIV(DIV), .ADDR_W(8), .DATA_W(8)) dut (
        .clk_fast_i(clk), .rst_n_i(rst_n), .go_i(go), .rw_i(rw),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .done_o(done),
        .slow_clk_o(slow_clk), .ale_o(ale), .rd_n_o(rd_n), .wr_n_o(wr_n),
        .ad_o(ad_o), .ad_i(ad_i), .ad_oe_o(ad_oe)
    );

    // chip model on the pins
    logic [7:0] mem [256];
    logic [7:0] chip_addr = '0;
    initial for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    always @(negedge ale) chip_addr = ad_o;
    always @(posedge wr_n) if (ad_oe) mem[chip_addr] = ad_o;
    assign ad_i = (!rd_n) ? mem[chip_addr] : 8'h00;

    // behavioural timing model
    logic [7:0] exp_mem [256];
    initial for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i * 7 + 3);
    int ph = 0, t = -1;
    logic m_rw = 1'b1;
    logic [7:0] m_addr = '0, m_wd = '0, m_rdata = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; t = -1; m_rdata = '0;
        end else begin
            if (t == DIV - 1 && m_rw)  m_rdata = exp_mem[m_addr];
            if (t == DIV - 1 && !m_rw) exp_mem[m_addr] = m_wd;
            if (t >= 0 && t < 2 * DIV - 1) t = t + 1;
            else if (ph == DIV - 1 && go) begin
                t = 0; m_rw = rw; m_addr = addr; m_wd = wdata;
            end else t = -1;
            ph = (ph + 1) % DIV;
        end
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s (%s) %s: actual %0h expected %0h at cycle %0d",
                     req, scn, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        logic e_ale, e_rdn, e_wrn, e_oe, e_done, e_slow, stb;
        cycles++;
        if (ale && !prev_ale) ale_cnt++;
        prev_ale = ale;
        stb    = (t >= 2 && t <= DIV - 1);
        e_slow = (ph < DIV / 2);
        e_ale  = (t == 0);
        e_rdn  = !(stb && m_rw);
        e_wrn  = !(stb && !m_rw);
        e_oe   = (t == 0 || t == 1 || (!m_rw && t >= 2 && t <= DIV));
        e_done = (t >= DIV);
        if (!rst_n) begin
            chk(!ale && rd_n && wr_n && !ad_oe && !done && rdata == 0 && slow_clk,
                "R10", "reset outputs", {ale, rd_n, wr_n, ad_oe, done, slow_clk}, 6'b011001);
        end else begin
            chk(slow_clk == e_slow, "R1", "slow_clk", slow_clk, e_slow);
            chk(ale == e_ale, "R3", "ale", ale, e_ale);
            chk(rd_n == e_rdn, "R4", "rd_n", rd_n, e_rdn);
            chk(wr_n == e_wrn, "R5", "wr_n", wr_n, e_wrn);
            chk(ad_oe == e_oe, (t < 0) ? "R8" : "R3", "ad_oe", ad_oe, e_oe);
            if (e_oe)
                chk(ad_o == ((t < 2) ? m_addr : m_wd), (t < 2) ? "R3" : "R5", "ad_o",
                    ad_o, (t < 2) ? m_addr : m_wd);
            chk(done == e_done, "R7", "done", done, e_done);
            chk(rdata == m_rdata, "R6", "rdata", rdata, m_rdata);
        end
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cycles);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    task automatic wait_boundary();
        do @(negedge clk); while (ph != DIV - 1);
    endtask

    // issue at a sampling edge; returns at the next back-to-back sampling point
    task automatic issue(input logic r, input logic [7:0] a, input logic [7:0] d);
        wait_boundary();
        go = 1'b1; rw = r; addr = a; wdata = d;
        @(negedge clk);
        go = 1'b0;
        repeat (2 * DIV - 2) @(negedge clk);
    endtask

    initial begin
        int base;
        scn = "R10";
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        scn = "R8";
        repeat (10) @(negedge clk);

        scn = "R5"; issue(1'b0, 8'h10, 8'hA5); repeat (6) @(negedge clk);
        scn = "R4"; issue(1'b1, 8'h10, 8'h00); repeat (6) @(negedge clk);
        chk(rdata == 8'hA5, "R6", "read after write", rdata, 8'hA5);
        scn = "R4"; issue(1'b1, 8'h33, 8'h00); repeat (6) @(negedge clk);
        chk(rdata == 8'(8'h33 * 7 + 3), "R6", "read untouched reg", rdata, 8'(8'h33 * 7 + 3));
        scn = "R6"; issue(1'b0, 8'hFF, 8'hFF); repeat (6) @(negedge clk);
        chk(rdata == 8'(8'h33 * 7 + 3), "R6", "write leaves rdata", rdata, 8'(8'h33 * 7 + 3));

        // R2: go at a non-sampling phase is ignored
        scn = "R2";
        base = ale_cnt;
        wait_boundary();
        @(negedge clk);
        go = 1'b1; rw = 1'b0; addr = 8'h44; wdata = 8'h99;
        @(negedge clk);
        go = 1'b0;
        repeat (3 * DIV) @(negedge clk);
        chk(ale_cnt == base, "R2", "ale pulses after off-phase go", ale_cnt - base, 0);
        chk(mem[8'h44] == 8'(8'h44 * 7 + 3), "R2", "chip reg untouched", mem[8'h44], 8'(8'h44 * 7 + 3));

        // R9: back-to-back requests
        scn = "R9";
        base = ale_cnt;
        issue(1'b0, 8'h00, 8'h5C);
        issue(1'b1, 8'h00, 8'h00);
        issue(1'b1, 8'hFF, 8'h00);
        repeat (2) @(negedge clk);
        chk(ale_cnt == base + 3, "R9", "ale pulses back-to-back", ale_cnt - base, 3);
        repeat (4 * DIV) @(negedge clk);
        chk(rdata == 8'hFF, "R6", "last read value", rdata, 8'hFF);
        chk(mem[8'h00] == 8'h5C, "R5", "chip reg written", mem[8'h00], 8'h5C);

        scn = "R8";
        repeat (10) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule